// File: doc/BRIEF.md
# SMBus Host Block-Data Buffer

This block is the 32-byte store that backs the block-data register of an SMBus host controller. Software can load a whole outgoing block through repeated writes to one register offset, or collect a whole incoming block through repeated reads, without a per-byte handshake with the bus engine. The register side has its own index. That index moves by one on every block-data access, and a read of the host control register returns it to zero as a side effect. The bus engine reaches the same storage through two streams: a transmit stream that offers the bytes in order and a receive stream that stores bytes as they arrive. The engine has a separate index, cleared when a transfer starts.

The auxiliary control register holds two read/write bits, one for buffer enable and one for hardware CRC enable. The auxiliary status register holds two sticky flags: index overflow and illegal received count. The buffer is only in use while its enable bit is set. When the bit is clear, the block-data offset behaves as a single holding byte shared by software and engine. The transmit stream obeys normal valid/ready rules: `tx_valid` stays high and `tx_data` stays unchanged until `tx_ready` accepts the byte. The receive stream never applies back-pressure, so `rx_ready` is always high.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset the buffer and CRC enables are 0, both status flags are 0, the auxiliary control (offset 13) and status (offset 12) registers read 0, and `tx_valid` is 0.
- R2: At offset 13, bit 1 is buffer enable and bit 0 is CRC enable. Both bits are read/write and appear on `buf_en` and `crc_en`. Bits 7:2 read as 0.
- R3: With the buffer enabled, each write to offset 7 stores the byte at the register-side index and each read of offset 7 returns the byte at that index. In both cases the index then advances by one.
- R4: A read of offset 2 (host control) resets the register-side index to 0. A write to offset 2 leaves the index unchanged.
- R5: An index stops at slot 31 once 32 accesses have been made. Any further access reuses slot 31 and sets the sticky overflow flag (offset 12 bit 0, `ovf_flag`). This applies to register accesses and to engine pushes.
- R6: Writing 1 to bit 0 or bit 1 of offset 12 clears the matching flag. A flag that is set and cleared in the same cycle ends up set.
- R7: With the buffer disabled, offset 7 is a single holding byte: a read returns the last byte written. The register-side index does not move, and the overflow flag is not set.
- R8: A pulse on `xfer_start` clears the engine index and latches `xfer_len`, limited to 32. The transmit stream then offers slots 0 to len-1 in order, and `tx_valid` stays low once they have all been accepted or when len is 0.
- R9: Each cycle with `rx_valid` high stores `rx_data` at the engine index and advances that index. `rx_ready` is always 1. Software reads the stored bytes back through offset 7.
- R10: A `rx_cnt_valid` pulse with `rx_cnt` equal to 0 or greater than 32 sets the sticky illegal-count flag (offset 12 bit 1, `cnt_err`). Counts from 1 to 32 leave the flag unchanged.
- R11: The register-side index and the engine index are independent. Engine traffic does not move the register-side index, and register accesses do not move the engine index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset of the current access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| xfer_start | input | 1 | Transfer start pulse; clears the engine index |
| xfer_len | input | 6 | Byte count to transmit, latched on `xfer_start` |
| tx_valid | output | 1 | A transmit byte is offered |
| tx_ready | input | 1 | Engine accepts the offered byte |
| tx_data | output | 8 | Byte offered for transmission |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 8 | Received byte |
| rx_cnt_valid | input | 1 | Received count is present |
| rx_cnt | input | 8 | Received block count to be checked |
| buf_en | output | 1 | Buffer enable bit |
| crc_en | output | 1 | Hardware CRC enable bit |
| ovf_flag | output | 1 | Sticky index-overflow flag |
| cnt_err | output | 1 | Sticky illegal-count flag |

## Verification
The embedded properties rely on three conditions on the inputs. The engine never pushes and pops in the same cycle. `xfer_start` never coincides with a push or a pop. `reg_wr` and `reg_rd` are never high together. The bench meets all three by driving exactly one activity per cycle from serial tasks. It changes inputs only on the falling edge and lowers each strobe right after the following rising edge.

// File: rtl/smbus_blkbuf_pkg.sv
package smbus_blkbuf_pkg;
  localparam int unsigned BB_DW     = 8;
  localparam int unsigned BB_AW     = 4;
  // register offsets the surrounding host decodes
  localparam int unsigned OFS_CTRL  = 2;
  localparam int unsigned OFS_BLK   = 7;
  localparam int unsigned OFS_AUXS  = 12;
  localparam int unsigned OFS_AUXC  = 13;
  // bit positions
  localparam int unsigned AUXC_CRC  = 0;
  localparam int unsigned AUXC_BUF  = 1;
  localparam int unsigned AUXS_OVF  = 0;
  localparam int unsigned AUXS_BAD  = 1;
endpackage

// File: rtl/smbus_blkbuf_ptr.sv
module smbus_blkbuf_ptr #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic [SW-1:0] slot,
  output logic          past_end
);
  assign past_end = (cnt == CW'(DEPTH));
  assign slot     = past_end ? SW'(DEPTH - 1) : cnt[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (step && !past_end)  cnt <= cnt + 1'b1;
  end

  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !past_end) |=> (cnt == $past(cnt) + 1'b1));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/smbus_blkbuf_store.sv
module smbus_blkbuf_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          h_we,
  input  logic [SW-1:0] h_slot,
  input  logic [DW-1:0] h_wdata,
  input  logic          e_we,
  input  logic [SW-1:0] e_slot,
  input  logic [DW-1:0] e_wdata,
  output logic [DW-1:0] h_rdata,
  output logic [DW-1:0] e_rdata
);
  logic [DEPTH-1:0][DW-1:0] mem;
  logic [DW-1:0]            hold;

  // engine write takes priority on a slot collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (e_we && e_slot == SW'(i))      mem[i] <= e_wdata;
        else if (h_we && h_slot == SW'(i)) mem[i] <= h_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           hold <= '0;
    else if (!en && e_we) hold <= e_wdata;
    else if (!en && h_we) hold <= h_wdata;
  end

  assign h_rdata = en ? mem[h_slot] : hold;
  assign e_rdata = en ? mem[e_slot] : hold;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && h_we && !e_we) |=> (h_rdata == $past(h_wdata) || en));
endmodule

// File: rtl/smbus_blkbuf_aux.sv
module smbus_blkbuf_aux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic       wr_sts,
  input  logic [1:0] wbits,
  input  logic       set_ovf,
  input  logic       set_bad,
  output logic       buf_en,
  output logic       crc_en,
  output logic       ovf,
  output logic       bad
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_en <= 1'b0;
      crc_en <= 1'b0;
    end else if (wr_ctl) begin
      buf_en <= wbits[1];
      crc_en <= wbits[0];
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      bad <= 1'b0;
    end else begin
      if (set_ovf)                 ovf <= 1'b1;
      else if (wr_sts && wbits[0]) ovf <= 1'b0;
      if (set_bad)                 bad <= 1'b1;
      else if (wr_sts && wbits[1]) bad <= 1'b0;
    end
  end

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_sts && wbits[0])) |=> ovf);
  assert_setwins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_bad |=> bad);
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf
  import smbus_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BB_AW-1:0] reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BB_DW-1:0] reg_wdata,
  output logic [BB_DW-1:0] reg_rdata,
  input  logic             xfer_start,
  input  logic [CW-1:0]    xfer_len,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [BB_DW-1:0] tx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [BB_DW-1:0] rx_data,
  input  logic             rx_cnt_valid,
  input  logic [BB_DW-1:0] rx_cnt,
  output logic             buf_en,
  output logic             crc_en,
  output logic             ovf_flag,
  output logic             cnt_err
);
  logic          hit_blk, hit_ctrl, h_acc, h_clr;
  logic [CW-1:0] h_cnt, e_cnt, len_q;
  logic [SW-1:0] h_slot, e_slot;
  logic          h_past, e_past, tx_fire, e_step;
  logic [BB_DW-1:0] h_rdata;
  logic          set_ovf, set_bad;

  assign hit_blk  = (reg_addr == BB_AW'(OFS_BLK));
  assign hit_ctrl = (reg_addr == BB_AW'(OFS_CTRL));
  assign h_acc    = (reg_wr || reg_rd) && hit_blk && buf_en;
  assign h_clr    = reg_rd && hit_ctrl;

  assign rx_ready = 1'b1;
  assign tx_valid = (e_cnt < len_q);
  assign tx_fire  = tx_valid && tx_ready;
  assign e_step   = tx_fire || rx_valid;

  smbus_blkbuf_ptr #(.DEPTH(DEPTH)) u_hptr (
    .clk(clk), .rst_n(rst_n), .clr(h_clr), .step(h_acc),
    .cnt(h_cnt), .slot(h_slot), .past_end(h_past));

  smbus_blkbuf_ptr #(.DEPTH(DEPTH)) u_eptr (
    .clk(clk), .rst_n(rst_n), .clr(xfer_start), .step(e_step),
    .cnt(e_cnt), .slot(e_slot), .past_end(e_past));

  smbus_blkbuf_store #(.DEPTH(DEPTH), .DW(BB_DW)) u_store (
    .clk(clk), .rst_n(rst_n), .en(buf_en),
    .h_we(reg_wr && hit_blk), .h_slot(h_slot), .h_wdata(reg_wdata),
    .e_we(rx_valid), .e_slot(e_slot), .e_wdata(rx_data),
    .h_rdata(h_rdata), .e_rdata(tx_data));

  assign set_ovf = (h_acc && h_past) || (buf_en && rx_valid && e_past);
  assign set_bad = rx_cnt_valid && ((rx_cnt == '0) || (int'(rx_cnt) > DEPTH));

  smbus_blkbuf_aux u_aux (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(reg_wr && reg_addr == BB_AW'(OFS_AUXC)),
    .wr_sts(reg_wr && reg_addr == BB_AW'(OFS_AUXS)),
    .wbits(reg_wdata[1:0]),
    .set_ovf(set_ovf), .set_bad(set_bad),
    .buf_en(buf_en), .crc_en(crc_en), .ovf(ovf_flag), .bad(cnt_err));

  always_ff @(posedge clk) begin
    if (!rst_n)          len_q <= '0;
    else if (xfer_start) len_q <= (int'(xfer_len) > DEPTH) ? CW'(DEPTH) : xfer_len;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      BB_AW'(OFS_BLK):  reg_rdata = h_rdata;
      BB_AW'(OFS_AUXS): begin
        reg_rdata[AUXS_OVF] = ovf_flag;
        reg_rdata[AUXS_BAD] = cnt_err;
      end
      BB_AW'(OFS_AUXC): begin
        reg_rdata[AUXC_CRC] = crc_en;
        reg_rdata[AUXC_BUF] = buf_en;
      end
      default: reg_rdata = '0;
    endcase
  end

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && hit_blk && (reg_wr || reg_rd)) |=> (h_cnt == $past(h_cnt)));
  assert_txhold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !xfer_start && !rx_valid && !reg_wr)
      |=> (tx_valid && $stable(tx_data)));
  assert_onedir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_fire));
  assert_badcnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt_valid && rx_cnt == '0) |=> cnt_err);
  assert_indep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (e_step && !h_acc && !h_clr) |=> (h_cnt == $past(h_cnt)));
endmodule

// File: tb/smbus_blkbuf_tb.sv
module smbus_blkbuf_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic xfer_start = 0;
  logic [5:0] xfer_len = 0;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic rx_cnt_valid = 0;
  logic [7:0] rx_cnt = 0;
  logic buf_en, crc_en, ovf_flag, cnt_err;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [32];

  always #10 clk = ~clk;

  smbus_blkbuf u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #5 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic start(input logic [5:0] n);
    @(negedge clk); xfer_len = n; xfer_start = 1;
    @(posedge clk); #1 xfer_start = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(13, d); chk("R1 auxctl", d, 8'h00);
    rd(12, d); chk("R1 auxsts", d, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1 buf_en", {7'b0, buf_en}, 8'h00);
  endtask

  task automatic t_auxctl();
    logic [7:0] d;
    wr(13, 8'hFF); rd(13, d); chk("R2 readback", d, 8'h03);
    chk("R2 pins", {6'b0, buf_en, crc_en}, 8'h03);
    wr(13, 8'h02); rd(13, d); chk("R2 crc off", d, 8'h02);
    chk("R2 crc pin", {7'b0, crc_en}, 8'h00);
  endtask

  task automatic t_fill();
    logic [7:0] d;
    rd(2, d);
    for (int i = 0; i < 32; i++) begin
      model[i] = 8'(i * 7 + 3); wr(7, model[i]);
    end
    rd(2, d);
    for (int i = 0; i < 32; i++) begin rd(7, d); chk("R3 readback", d, model[i]); end
    rd(2, d);
    wr(7, 8'hA0); wr(7, 8'hA1); wr(2, 8'h00); wr(7, 8'hA2);
    model[0] = 8'hA0; model[1] = 8'hA1; model[2] = 8'hA2;
    rd(2, d);
    for (int i = 0; i < 3; i++) begin rd(7, d); chk("R4 ctrl write keeps index", d, model[i]); end
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    rd(2, d);
    for (int i = 0; i < 32; i++) begin model[i] = 8'hC0 + 8'(i); wr(7, model[i]); end
    chk("R5 no flag at 32", {7'b0, ovf_flag}, 8'h00);
    wr(7, 8'hEE); model[31] = 8'hEE;
    chk("R5 flag at 33", {7'b0, ovf_flag}, 8'h01);
    rd(2, d);
    for (int i = 0; i < 32; i++) rd(7, d);
    chk("R5 slot31 overwritten", d, 8'hEE);
    rd(7, d); chk("R5 reread slot31", d, 8'hEE);
    rd(12, d); chk("R5 status", d, 8'h01);
    wr(12, 8'h01); rd(12, d); chk("R6 clear ovf", d, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    rd(2, d); rd(7, d);
    wr(13, 8'h00);
    wr(7, 8'h5A); wr(7, 8'h5B);
    rd(7, d); chk("R7 hold", d, 8'h5B);
    rd(7, d); chk("R7 hold reread", d, 8'h5B);
    rd(12, d); chk("R7 no ovf", d, 8'h00);
    wr(13, 8'h02);
    rd(7, d); chk("R7 index unmoved", d, model[1]);
  endtask

  task automatic pop_expect(int n);
    int k = 0;
    for (int c = 0; c < 200 && k < n; c++) begin
      @(negedge clk); tx_ready = (c % 3) != 0;
      #5;
      if (tx_valid && tx_ready) begin chk("R8 tx order", tx_data, model[k]); k++; end
    end
    @(posedge clk); #1 tx_ready = 0;
    chk("R8 pop count", 8'(k), 8'(n));
    @(negedge clk); #5 chk("R8 valid low after end", {7'b0, tx_valid}, 8'h00);
  endtask

  task automatic t_tx();
    start(6'd5);  pop_expect(5);
    start(6'd40); pop_expect(32);
    start(6'd0);  @(negedge clk); #5 chk("R8 zero length", {7'b0, tx_valid}, 8'h00);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    logic [7:0] v [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    start(6'd0);
    rd(2, d); rd(7, d); chk("R9 pre", d, model[0]);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = v[i];
      #5 chk("R9 rx_ready", {7'b0, rx_ready}, 8'h01);
      @(posedge clk); #1 rx_valid = 0;
      model[i] = v[i];
    end
    rd(7, d); chk("R11 host index kept", d, model[1]);
    rd(2, d);
    for (int i = 0; i < 4; i++) begin rd(7, d); chk("R9 pushed bytes", d, model[i]); end
  endtask

  task automatic cnt_pulse(input logic [7:0] n);
    @(negedge clk); rx_cnt = n; rx_cnt_valid = 1;
    @(posedge clk); #1 rx_cnt_valid = 0;
  endtask

  task automatic t_cnt();
    logic [7:0] d;
    cnt_pulse(0);  chk("R10 zero", {7'b0, cnt_err}, 8'h01);
    wr(12, 8'h02); chk("R6 clear bad", {7'b0, cnt_err}, 8'h00);
    cnt_pulse(32); chk("R10 32 ok", {7'b0, cnt_err}, 8'h00);
    cnt_pulse(1);  chk("R10 1 ok", {7'b0, cnt_err}, 8'h00);
    cnt_pulse(33); chk("R10 33", {7'b0, cnt_err}, 8'h01);
    rd(12, d);     chk("R10 status", d, 8'h02);
    wr(12, 8'h02); rd(12, d); chk("R6 cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_auxctl(); t_fill(); t_overflow();
    t_disabled(); t_tx(); t_rx(); t_cnt();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule